// File: doc/BRIEF.md
# Monte Carlo Faulty-Gate Reliability Estimator

The block estimates how reliable a small NAND-only logic network is when every gate can fail at random. It builds two copies of a balanced binary tree of two-input NAND gates. In one copy, each gate sits inside a fault-injection cell. In the other copy, the gates are fault-free and give the reference result. Each cell has its own pseudo-random control bit: a 1 lets the gate work, and a 0 makes it misbehave according to one fault model chosen for the whole run. All gates fail independently with the same programmable probability.

To start a run, software applies a one-cycle start pulse. The pulse latches the primary-input vector, the fault model, the failure threshold, the trial count and the seed. After that, the block evaluates one trial per clock. On each trial it compares the faulty tree output with the reference output (their XNOR) and counts the trials where the two agree. When the programmed number of trials is complete, it pulses done. Both counters then hold until the next start. The ratio of the two counts is the reliability estimate for that input vector.

Top module: `fault_rel_est`

## Requirements
- R1: While rst is high, and in the cycle after it falls, done is 0 and both counters are 0.
- R2: A start pulse clears both counters. Each later cycle adds one trial to total_cnt. In the cycle where total_cnt first equals the latched trial count, done is 1, and only in that cycle. After that, both counters hold until the next start.
- R3: A start with a trial count of 0 gives done=1 in the next cycle, with both counters at 0.
- R4: Gate j (0 to 2^DEPTH-2) has a 16-bit register. On start it loads seed + 0x03B1*(j+1) modulo 2^16, or 0xACE1 if that sum is 0. After each trial it shifts left, taking bit15^bit13^bit12^bit10 into bit 0. The gate's control bit is 0 (failed) in a trial exactly when the register's low 8 bits, read as an unsigned number, are below the 9-bit threshold (0 to 256).
- R5: fault_mode 0 (and the unused code 3) selects flip faults: a failed gate outputs the complement of its NAND result.
- R6: fault_mode 1 selects stuck faults: a failed gate outputs 1.
- R7: fault_mode 2 selects pass faults: a failed gate outputs its first (a) input.
- R8: The tree is indexed as follows. Node 0 is the output. Gate j takes a = node 2j+1 and b = node 2j+2. Node 2^DEPTH-1+i is pi_vec[i]. A trial is counted in pass_cnt when the faulty output equals the reference output.
- R9: With a threshold of 0, no gate ever fails, so pass_cnt equals total_cnt at every cycle of the run.
- R10: pi_vec, fault_mode, fail_thr, trial_cnt and seed are used only at start. Changing them during a run has no effect on the counts.
- R11: A start pulse during a run abandons that run and begins a new one, exactly as if the block were idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that latches the configuration and begins a run |
| pi_vec | input | 2^DEPTH | Primary inputs of the tree, fixed for a run |
| fault_mode | input | 2 | Fault model: 0 flip, 1 stuck at 1, 2 pass, 3 flip |
| fail_thr | input | 9 | Failure threshold in 1/256 steps (0 to 256) |
| trial_cnt | input | CNT_W | Number of trials to run |
| seed | input | 16 | Seed from which the per-gate generator seeds are derived |
| done | output | 1 | One-cycle pulse when the run completes |
| pass_cnt | output | CNT_W | Trials in which the faulty output matched the reference |
| total_cnt | output | CNT_W | Trials evaluated so far |

## Verification
A wrong generator state, a swapped fault model or a miswired tree node first changes which trials are counted as agreeing. This appears in pass_cnt in the very next cycle, because the bench's reference model reproduces every generator and every tree node and compares both counters on every clock. A wrong trial counter or a wrong done condition shows as a total_cnt or done mismatch in the cycle it occurs. Saturated thresholds make each fault model fully deterministic, so a mode-decode error shows as a count of all-zero or all-pass that is wrong for the chosen input vector.

// File: rtl/fre_pkg.sv
package fre_pkg;
  localparam int LFSR_W = 16;
  localparam int THR_W  = 9;

  typedef enum logic [1:0] {
    FM_FLIP   = 2'd0,
    FM_STUCK1 = 2'd1,
    FM_PASS   = 2'd2,
    FM_RSVD   = 2'd3
  } fault_mode_e;

  // Per-gate starting state, never zero.
  function automatic logic [LFSR_W-1:0] gate_seed(input logic [LFSR_W-1:0] s,
                                                   input int unsigned idx);
    logic [LFSR_W-1:0] v;
    v = s + LFSR_W'(32'h03B1 * (idx + 1));
    if (v == '0) v = 16'hACE1;
    return v;
  endfunction
endpackage

// File: rtl/fre_lfsr.sv
module fre_lfsr
  import fre_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [LFSR_W-1:0] seed_val,
  output logic [LFSR_W-1:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (rst)       state <= 16'h0001;
    else if (load) state <= seed_val;
    else if (step) state <= {state[LFSR_W-2:0], fb};
  end
endmodule

// File: rtl/fre_fault_cell.sv
module fre_fault_cell
  import fre_pkg::*;
(
  input  logic        a,
  input  logic        b,
  input  logic        ok,
  input  fault_mode_e mode,
  output logic        y
);
  logic nand_y;
  assign nand_y = ~(a & b);

  always_comb begin
    unique case (mode)
      FM_STUCK1: y = ~(a & b & ok);
      FM_PASS:   y = ok ? nand_y : a;
      default:   y = nand_y ^ ~ok;
    endcase
  end
endmodule

// File: rtl/fre_nand_tree.sv
module fre_nand_tree
  import fre_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int N_IN = 1 << DEPTH,
  localparam int NG   = N_IN - 1
)(
  input  logic [N_IN-1:0] x,
  input  logic [NG-1:0]   ok,
  input  fault_mode_e     mode,
  output logic            y
);
  logic nd [2*N_IN-1];

  for (genvar i = 0; i < N_IN; i++) begin : g_leaf
    assign nd[NG+i] = x[i];
  end

  for (genvar j = 0; j < NG; j++) begin : g_gate
    fre_fault_cell u_cell (
      .a    (nd[2*j+1]),
      .b    (nd[2*j+2]),
      .ok   (ok[j]),
      .mode (mode),
      .y    (nd[j])
    );
  end

  assign y = nd[0];
endmodule

// File: rtl/fault_rel_est.sv
module fault_rel_est
  import fre_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = 16,
  localparam int N_IN = 1 << DEPTH,
  localparam int NG   = N_IN - 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N_IN-1:0]  pi_vec,
  input  logic [1:0]       fault_mode,
  input  logic [THR_W-1:0] fail_thr,
  input  logic [CNT_W-1:0] trial_cnt,
  input  logic [LFSR_W-1:0] seed,
  output logic             done,
  output logic [CNT_W-1:0] pass_cnt,
  output logic [CNT_W-1:0] total_cnt
);
  logic              busy_q, done_q;
  logic [CNT_W-1:0]  left_q, total_q, pass_q;
  logic [N_IN-1:0]   x_q;
  fault_mode_e       mode_q;
  logic [THR_W-1:0]  thr_q;
  logic [NG-1:0]     ok_bits;
  logic              faulty_y, ideal_y, match;
  logic              step;

  assign step = busy_q & ~start;

  for (genvar j = 0; j < NG; j++) begin : g_ctl
    logic [LFSR_W-1:0] st;
    fre_lfsr u_lfsr (
      .clk      (clk),
      .rst      (rst),
      .load     (start),
      .step     (step),
      .seed_val (gate_seed(seed, j)),
      .state    (st)
    );
    assign ok_bits[j] = ~({1'b0, st[7:0]} < thr_q);
  end

  fre_nand_tree #(.DEPTH(DEPTH)) u_faulty (
    .x(x_q), .ok(ok_bits), .mode(mode_q), .y(faulty_y)
  );

  fre_nand_tree #(.DEPTH(DEPTH)) u_ideal (
    .x(x_q), .ok({NG{1'b1}}), .mode(FM_FLIP), .y(ideal_y)
  );

  assign match = ~(faulty_y ^ ideal_y);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      left_q  <= '0;
      total_q <= '0;
      pass_q  <= '0;
      x_q     <= '0;
      mode_q  <= FM_FLIP;
      thr_q   <= '0;
    end else if (start) begin
      x_q     <= pi_vec;
      mode_q  <= fault_mode_e'(fault_mode);
      thr_q   <= fail_thr;
      left_q  <= trial_cnt;
      total_q <= '0;
      pass_q  <= '0;
      busy_q  <= (trial_cnt != '0);
      done_q  <= (trial_cnt == '0);
    end else if (busy_q) begin
      total_q <= total_q + 1'b1;
      pass_q  <= pass_q + CNT_W'(match);
      left_q  <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done      = done_q;
  assign pass_cnt  = pass_q;
  assign total_cnt = total_q;

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q && !start |=> !done_q);

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    busy_q && !start |=> total_q == $past(total_q) + 1'b1);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !start |=> $stable(total_q) && $stable(pass_q));

  a_r8_pass_bound: assert property (@(posedge clk) disable iff (rst)
    pass_q <= total_q);

  a_r9_thr_zero: assert property (@(posedge clk) disable iff (rst)
    busy_q && thr_q == '0 |-> match);

  a_r6_stuck_all: assert property (@(posedge clk) disable iff (rst)
    busy_q && mode_q == FM_STUCK1 && thr_q == 9'd256 |-> faulty_y);
endmodule

// File: tb/fault_rel_est_tb.sv
module fault_rel_est_tb;
  localparam int DEPTH = 2;
  localparam int CNT_W = 16;
  localparam int N_IN  = 1 << DEPTH;
  localparam int NG    = N_IN - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N_IN-1:0] pi_vec = '0;
  logic [1:0] fault_mode = '0;
  logic [8:0] fail_thr = '0;
  logic [CNT_W-1:0] trial_cnt = '0;
  logic [15:0] seed = '0;
  logic done;
  logic [CNT_W-1:0] pass_cnt, total_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  fault_rel_est #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .pi_vec(pi_vec),
    .fault_mode(fault_mode), .fail_thr(fail_thr), .trial_cnt(trial_cnt),
    .seed(seed), .done(done), .pass_cnt(pass_cnt), .total_cnt(total_cnt)
  );

  // Reference model state
  logic [15:0] m_lfsr [NG];
  logic [N_IN-1:0] m_x;
  int m_mode, m_thr, m_left, m_total, m_pass;
  bit m_busy, m_done;

  function automatic logic [15:0] seed_of(logic [15:0] s, int j);
    logic [15:0] v;
    v = s + 16'((32'h03B1 * (j + 1)) & 32'hFFFF);
    if (v == 16'h0) v = 16'hACE1;
    return v;
  endfunction

  function automatic logic [15:0] nxt(logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  // Evaluates the tree bottom-up; ideal when all_ok is set
  function automatic bit eval_tree(bit all_ok);
    bit v [2*N_IN-1];
    bit fail, a, b, r;
    for (int i = 0; i < N_IN; i++) v[NG+i] = m_x[i];
    for (int j = NG - 1; j >= 0; j--) begin
      a = v[2*j+1];
      b = v[2*j+2];
      r = !(a && b);
      fail = !all_ok && (int'(m_lfsr[j][7:0]) < m_thr);
      if (fail) begin
        if (m_mode == 1)      r = 1'b1;
        else if (m_mode == 2) r = a;
        else                  r = !r;
      end
      v[j] = r;
    end
    return v[0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_total = 0; m_pass = 0; m_left = 0;
    end else if (start) begin
      m_x = pi_vec; m_mode = fault_mode; m_thr = fail_thr;
      m_left = trial_cnt; m_total = 0; m_pass = 0;
      m_busy = (trial_cnt != 0); m_done = (trial_cnt == 0);
      for (int j = 0; j < NG; j++) m_lfsr[j] = seed_of(seed, j);
    end else if (m_busy) begin
      if (eval_tree(0) == eval_tree(1)) m_pass++;
      m_total++;
      m_left--;
      for (int j = 0; j < NG; j++) m_lfsr[j] = nxt(m_lfsr[j]);
      m_done = (m_left == 0);
      if (m_left == 0) m_busy = 0;
    end else begin
      m_done = 0;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      check(done == m_done, "R2 done", int'(done), int'(m_done));
      check(int'(total_cnt) == m_total, "R2 total_cnt", int'(total_cnt), m_total);
      check(int'(pass_cnt) == m_pass, "R4/R8 pass_cnt", int'(pass_cnt), m_pass);
    end
  end

  task automatic launch(logic [N_IN-1:0] x, int mode, int thr, int n, logic [15:0] s);
    @(negedge clk);
    pi_vec = x; fault_mode = 2'(mode); fail_thr = 9'(thr);
    trial_cnt = CNT_W'(n); seed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic run_final(logic [N_IN-1:0] x, int mode, int thr, int n,
                           logic [15:0] s, string tag, int exp_pass);
    launch(x, mode, thr, n, s);
    wait_done();
    check(int'(total_cnt) == n, {tag, " total"}, int'(total_cnt), n);
    if (exp_pass >= 0)
      check(int'(pass_cnt) == exp_pass, {tag, " pass"}, int'(pass_cnt), exp_pass);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(total_cnt == '0, "R1 total", int'(total_cnt), 0);
    check(pass_cnt == '0, "R1 pass", int'(pass_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && total_cnt == '0, "R1 after release", int'(total_cnt), 0);

    // R9: no failures at threshold 0
    run_final(4'b1010, 0, 0, 50, 16'h1234, "R9", 50);
    // R5: all gates flip; x0&x1=1, x2&x3=0 -> faulty 0, ideal 1
    run_final(4'b0011, 0, 256, 40, 16'h0042, "R5", 0);
    // R5: reserved code acts as flip
    run_final(4'b0011, 3, 256, 20, 16'h0042, "R5 code3", 0);
    // R6: all stuck -> output 1; ideal 0 for all-zero inputs
    run_final(4'b0000, 1, 256, 30, 16'h7777, "R6 zero", 0);
    run_final(4'b0011, 1, 256, 30, 16'h7777, "R6 one", 30);
    // R7: all pass -> output x0=1; ideal 0
    run_final(4'b0001, 2, 256, 25, 16'h0BAD, "R7", 0);
    run_final(4'b1001, 2, 256, 25, 16'h0BAD, "R7 match", -1);
    // R4/R8: random failures, each mode, checked against the model
    for (int m = 0; m < 3; m++)
      run_final(4'(m * 5 + 3), m, 64, 200, 16'(16'h5A5A + m), "R4 random", -1);
    // R8: seed whose gate-0 sum wraps to zero uses 0xACE1
    run_final(4'b0110, 0, 128, 100, 16'hFC4F, "R8 wrap", -1);

    // R3: zero trials
    launch(4'b1111, 0, 100, 0, 16'h1111);
    check(done == 1'b1, "R3 done", int'(done), 1);
    check(total_cnt == '0 && pass_cnt == '0, "R3 counts", int'(total_cnt), 0);
    repeat (2) @(negedge clk);

    // R10: inputs changed mid-run are ignored
    launch(4'b0011, 0, 256, 60, 16'h2222);
    repeat (10) @(negedge clk);
    pi_vec = 4'b1111; fault_mode = 2'd1; fail_thr = 9'd0; trial_cnt = 16'd5; seed = 16'h9999;
    wait_done();
    check(int'(total_cnt) == 60, "R10 total", int'(total_cnt), 60);
    check(pass_cnt == '0, "R10 pass", int'(pass_cnt), 0);
    repeat (3) @(negedge clk);

    // R11: restart during a run
    launch(4'b0011, 0, 256, 80, 16'h3333);
    repeat (15) @(negedge clk);
    launch(4'b0101, 0, 0, 30, 16'h4444);
    check(int'(total_cnt) == 0 || int'(total_cnt) == 1, "R11 cleared", int'(total_cnt), 0);
    wait_done();
    check(int'(total_cnt) == 30 && int'(pass_cnt) == 30, "R11 rerun",
          int'(pass_cnt), 30);
    // R2: held after done
    repeat (20) @(negedge clk);
    check(int'(total_cnt) == 30, "R2 hold", int'(total_cnt), 30);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule